// File: doc/BRIEF.md
# Serial Port FIFO Pair with Programmable Trigger Interrupts

This block holds the character buffers of a serial port. There is one receive FIFO and one transmit FIFO. Each is 16 bytes deep and has byte-wide push and pop ports. Each FIFO shows its current fill count and its own interrupt line.

A single control-byte write port sets the fill threshold for each direction and can flush either FIFO. Each direction has a 2-bit trigger code that picks one of four fixed levels: 1, 4, 8 or 14 characters.

- The receive interrupt is raised while the receive FIFO holds at least its chosen number of characters. It drops by itself once reads bring the count below that level.
- The transmit interrupt is raised while the transmit FIFO has drained to its chosen level or below. It tells the host that space is available.
- The serial shifters, baud generation, receive timeouts and bus decoding sit outside this block.

Top module: `serial_fifo_pair`

## Requirements
- R1: After rst_ni is released, both counts are 0, both data outputs are 0, both overrun flags are 0, both trigger codes are 00, rx_irq_o is 0 and tx_irq_o is 1.
- R2: Each FIFO returns bytes in the order they were pushed. An accepted pop updates the data output and the count on the next rising edge. The count never exceeds 16.
- R3: A push into a full FIFO (count 16) stores nothing. It leaves the count at 16 and sets that FIFO's overrun flag. The flag stays set until that FIFO is flushed or the block is reset.
- R4: A pop from an empty FIFO leaves the count at 0 and the data output at its previous value.
- R5: A control write (ctrl_we_i high) loads the receive trigger code from bits 7:6 and the transmit trigger code from bits 5:4. Codes 00, 01, 10 and 11 select levels 1, 4, 8 and 14.
- R6: rx_irq_o is 1 exactly when the receive count is greater than or equal to the receive level.
- R7: tx_irq_o is 1 exactly when the transmit count is less than or equal to the transmit level.
- R8: A control write with bit 1 set empties the receive FIFO and clears its overrun flag. A control write with bit 2 set does the same for the transmit FIFO. The effect is visible after that edge.
- R9: A flush takes priority over a push or pop to the same FIFO in the same cycle. Neither is performed, and the overrun flag is not set.
- R10: A push and a pop in the same cycle on a FIFO that is neither empty nor full both take effect and leave the count unchanged. On an empty FIFO only the push is done. On a full FIFO only the pop is done, and the push sets overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Control byte write strobe |
| ctrl_wdata_i | input | 8 | Control byte: [7:6] rx code, [5:4] tx code, [2] tx flush, [1] rx flush |
| rx_push_i | input | 1 | Push a received byte |
| rx_data_i | input | 8 | Byte to push into receive FIFO |
| rx_pop_i | input | 1 | Pop from receive FIFO |
| rx_data_o | output | 8 | Last byte popped from receive FIFO |
| rx_count_o | output | 5 | Receive FIFO fill count |
| rx_irq_o | output | 1 | Receive trigger interrupt |
| rx_overrun_o | output | 1 | Sticky receive overrun flag |
| tx_push_i | input | 1 | Push a byte to transmit |
| tx_data_i | input | 8 | Byte to push into transmit FIFO |
| tx_pop_i | input | 1 | Pop from transmit FIFO |
| tx_data_o | output | 8 | Last byte popped from transmit FIFO |
| tx_count_o | output | 5 | Transmit FIFO fill count |
| tx_irq_o | output | 1 | Transmit trigger interrupt |
| tx_overrun_o | output | 1 | Sticky transmit overrun flag |

## Verification
The assertions check several properties on every cycle:
- the count bound;
- that a push into a full FIFO is refused and raises overrun;
- that a pop from an empty FIFO leaves the count and data output unchanged;
- that a flush empties the FIFO;
- that the overrun flag stays set until cleared;
- that each interrupt changes only in a cycle that follows a push, pop or control write in its own direction.

Some behaviours only the bench scenarios can show:
- the exact byte order through the FIFO;
- the mapping from each trigger code to its level;
- the same-cycle interplay of flush, push and pop.

The bench covers these by comparing against a queue-based model on every clock.

// File: rtl/serial_fifo_pkg.sv
package serial_fifo_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned DEPTH  = 16;
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1);

  typedef logic [1:0] trig_code_t;

  function automatic logic [CNT_W-1:0] trig_level(input trig_code_t code);
    case (code)
      2'd0:    trig_level = CNT_W'(1);
      2'd1:    trig_level = CNT_W'(4);
      2'd2:    trig_level = CNT_W'(8);
      default: trig_level = CNT_W'(14);
    endcase
  endfunction
endpackage

// File: rtl/sf_fifo.sv
module sf_fifo
  import serial_fifo_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned DP = DEPTH,
  localparam int unsigned AW = $clog2(DP),
  localparam int unsigned CW = $clog2(DP + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] count_o,
  output logic          ovr_o
);
  logic [DW-1:0] mem_q [DP];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop, full, empty;

  assign full    = (cnt_q == CW'(DP));
  assign empty   = (cnt_q == '0);
  assign do_push = push_i && !full && !flush_i;
  assign do_pop  = pop_i && !empty && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      ovr_o  <= 1'b0;
      data_o <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovr_o <= 1'b0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop) begin
        rd_q   <= rd_q + 1'b1;
        data_o <= mem_q[rd_q];
      end
      if (push_i && full) ovr_o <= 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  assign count_o = cnt_q;

  assert_count_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DP));
  assert_full_push_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i && !flush_i) |=> (cnt_q == CW'(DP)) && ovr_o);
  assert_ovr_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !flush_i) |=> ovr_o);
  assert_empty_pop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty && !push_i && !flush_i) |=> (cnt_q == '0) && $stable(data_o));
  assert_flush_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_q == '0) && !ovr_o);
endmodule

// File: rtl/sf_irq_gen.sv
module sf_irq_gen
  import serial_fifo_pkg::*;
#(
  parameter bit IS_RX = 1'b1,
  localparam int unsigned CW = CNT_W
) (
  input  logic [CW-1:0] count_i,
  input  trig_code_t    code_i,
  output logic          irq_o
);
  logic [CW-1:0] level;
  assign level = trig_level(code_i);

  generate
    if (IS_RX) begin : g_rx
      assign irq_o = (count_i >= level);
    end else begin : g_tx
      assign irq_o = (count_i <= level);
    end
  endgenerate
endmodule

// File: rtl/serial_fifo_pair.sv
module serial_fifo_pair
  import serial_fifo_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  localparam int unsigned CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic [7:0]    ctrl_wdata_i,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_pop_i,
  output logic [DW-1:0] rx_data_o,
  output logic [CW-1:0] rx_count_o,
  output logic          rx_irq_o,
  output logic          rx_overrun_o,
  input  logic          tx_push_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_pop_i,
  output logic [DW-1:0] tx_data_o,
  output logic [CW-1:0] tx_count_o,
  output logic          tx_irq_o,
  output logic          tx_overrun_o
);
  trig_code_t rx_code_q, tx_code_q;
  logic       rx_flush, tx_flush;

  assign rx_flush = ctrl_we_i && ctrl_wdata_i[1];
  assign tx_flush = ctrl_we_i && ctrl_wdata_i[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_code_q <= 2'b00;
      tx_code_q <= 2'b00;
    end else if (ctrl_we_i) begin
      rx_code_q <= ctrl_wdata_i[7:6];
      tx_code_q <= ctrl_wdata_i[5:4];
    end
  end

  sf_fifo #(.DW(DW), .DP(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .flush_i(rx_flush),
    .push_i(rx_push_i), .data_i(rx_data_i), .pop_i(rx_pop_i),
    .data_o(rx_data_o), .count_o(rx_count_o), .ovr_o(rx_overrun_o)
  );

  sf_fifo #(.DW(DW), .DP(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .flush_i(tx_flush),
    .push_i(tx_push_i), .data_i(tx_data_i), .pop_i(tx_pop_i),
    .data_o(tx_data_o), .count_o(tx_count_o), .ovr_o(tx_overrun_o)
  );

  sf_irq_gen #(.IS_RX(1'b1)) u_rx_irq (
    .count_i(rx_count_o), .code_i(rx_code_q), .irq_o(rx_irq_o)
  );

  sf_irq_gen #(.IS_RX(1'b0)) u_tx_irq (
    .count_i(tx_count_o), .code_i(tx_code_q), .irq_o(tx_irq_o)
  );

  // Interrupt edges must be caused by traffic or a control write in the same direction.
  assert_rx_irq_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_irq_o) |-> $past(rx_push_i || ctrl_we_i));
  assert_rx_irq_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_irq_o) |-> $past(rx_pop_i || ctrl_we_i));
  assert_tx_irq_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_irq_o) |-> $past(tx_push_i || ctrl_we_i));
  assert_tx_irq_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_irq_o) |-> $past(tx_pop_i || ctrl_we_i));
endmodule

// File: tb/serial_fifo_pair_bench.sv
module serial_fifo_pair_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctrl_we_i = 1'b0;
  logic [7:0] ctrl_wdata_i = '0;
  logic       rx_push_i = 1'b0, rx_pop_i = 1'b0, tx_push_i = 1'b0, tx_pop_i = 1'b0;
  logic [7:0] rx_data_i = '0, tx_data_i = '0;
  logic [7:0] rx_data_o, tx_data_o;
  logic [4:0] rx_count_o, tx_count_o;
  logic       rx_irq_o, tx_irq_o, rx_overrun_o, tx_overrun_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  serial_fifo_pair u_serial_fifo_pair (.*);

  // Reference model
  logic [7:0] m_rxq[$], m_txq[$];
  logic [7:0] m_rx_out, m_tx_out;
  logic       m_rx_ovr, m_tx_ovr;
  logic [1:0] m_rx_code, m_tx_code;

  function automatic int lvl(input logic [1:0] c);
    return (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_rxq.delete(); m_txq.delete();
      m_rx_out = 0; m_tx_out = 0; m_rx_ovr = 0; m_tx_ovr = 0;
      m_rx_code = 0; m_tx_code = 0;
    end else begin
      bit rf, tf;
      rf = ctrl_we_i && ctrl_wdata_i[1];
      tf = ctrl_we_i && ctrl_wdata_i[2];
      if (ctrl_we_i) begin
        m_rx_code = ctrl_wdata_i[7:6];
        m_tx_code = ctrl_wdata_i[5:4];
      end
      if (rf) begin
        m_rxq.delete(); m_rx_ovr = 0;
      end else begin
        bit pu;
        pu = rx_push_i && m_rxq.size() < 16;
        if (rx_push_i && !pu) m_rx_ovr = 1;
        if (rx_pop_i && m_rxq.size() > 0) m_rx_out = m_rxq.pop_front();
        if (pu) m_rxq.push_back(rx_data_i);
      end
      if (tf) begin
        m_txq.delete(); m_tx_ovr = 0;
      end else begin
        bit pu;
        pu = tx_push_i && m_txq.size() < 16;
        if (tx_push_i && !pu) m_tx_ovr = 1;
        if (tx_pop_i && m_txq.size() > 0) m_tx_out = m_txq.pop_front();
        if (pu) m_txq.push_back(tx_data_i);
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk(rx_count_o, m_rxq.size(), "R2 rx_count");
      chk(tx_count_o, m_txq.size(), "R2 tx_count");
      chk(rx_data_o, m_rx_out, "R2 rx_data");
      chk(tx_data_o, m_tx_out, "R2 tx_data");
      chk(rx_overrun_o, m_rx_ovr, "R3 rx_overrun");
      chk(tx_overrun_o, m_tx_ovr, "R3 tx_overrun");
      chk(rx_irq_o, int'(m_rxq.size()) >= lvl(m_rx_code), "R6 rx_irq");
      chk(tx_irq_o, int'(m_txq.size()) <= lvl(m_tx_code), "R7 tx_irq");
    end
  end

  task automatic tick();
    @(posedge clk_i);
    #1;
    ctrl_we_i = 0; rx_push_i = 0; rx_pop_i = 0; tx_push_i = 0; tx_pop_i = 0;
  endtask

  task automatic ctrl(input logic [7:0] v);
    ctrl_we_i = 1; ctrl_wdata_i = v; tick();
  endtask

  task automatic rx_push(input logic [7:0] d);
    rx_push_i = 1; rx_data_i = d; tick();
  endtask

  task automatic tx_push(input logic [7:0] d);
    tx_push_i = 1; tx_data_i = d; tick();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    tick();
    // R1 reset state
    chk(rx_count_o, 0, "R1 rx_count"); chk(tx_count_o, 0, "R1 tx_count");
    chk(rx_irq_o, 0, "R1 rx_irq");     chk(tx_irq_o, 1, "R1 tx_irq");
    chk(rx_overrun_o, 0, "R1 rx_ovr"); chk(rx_data_o, 0, "R1 rx_data");
    // R6 default level 1
    rx_push(8'hA1);
    chk(rx_irq_o, 1, "R6 level1");
    // R5 rx code 01 -> level 4
    ctrl(8'b01_00_0000);
    chk(rx_irq_o, 0, "R5 rx code01");
    rx_push(8'hA2); rx_push(8'hA3);
    chk(rx_irq_o, 0, "R6 below 4");
    rx_push(8'hA4);
    chk(rx_irq_o, 1, "R6 at 4");
    // R2 order
    rx_pop_i = 1; tick();
    chk(rx_data_o, 8'hA1, "R2 first out");
    chk(rx_irq_o, 0, "R6 drop below");
    // R10 simultaneous push/pop
    rx_push_i = 1; rx_data_i = 8'hA5; rx_pop_i = 1; tick();
    chk(rx_count_o, 3, "R10 count held");
    chk(rx_data_o, 8'hA2, "R10 popped");
    // R3 fill and overrun, code 11 -> 14
    ctrl(8'b11_00_0000);
    for (int i = 0; i < 13; i++) rx_push(8'(8'h10 + i));
    chk(rx_count_o, 16, "R3 full");
    chk(rx_irq_o, 1, "R5 level14");
    rx_push(8'hEE);
    chk(rx_count_o, 16, "R3 full push ignored");
    chk(rx_overrun_o, 1, "R3 overrun set");
    // R10 full: pop + push, push dropped
    rx_push_i = 1; rx_data_i = 8'hEF; rx_pop_i = 1; tick();
    chk(rx_count_o, 15, "R10 full push dropped");
    // R9 flush with push same cycle
    ctrl_wdata_i = 8'b00_00_0010; ctrl_we_i = 1; rx_push_i = 1; rx_data_i = 8'h55; tick();
    chk(rx_count_o, 0, "R9 flush wins");
    chk(rx_overrun_o, 0, "R8 overrun cleared");
    // R4 pop empty
    rx_push(8'h66);
    rx_pop_i = 1; tick();
    chk(rx_data_o, 8'h66, "R4 setup");
    rx_pop_i = 1; tick();
    chk(rx_count_o, 0, "R4 count");
    chk(rx_data_o, 8'h66, "R4 data held");
    // R7 tx code 10 -> level 8
    ctrl(8'b00_10_0000);
    for (int i = 0; i < 9; i++) tx_push(8'(8'h30 + i));
    chk(tx_irq_o, 0, "R7 above 8");
    tx_pop_i = 1; tick();
    chk(tx_irq_o, 1, "R7 at 8");
    chk(tx_data_o, 8'h30, "R2 tx first out");
    ctrl(8'b00_01_0000);
    chk(tx_irq_o, 0, "R5 tx code01");
    // R8 tx flush
    ctrl(8'b00_01_0100);
    chk(tx_count_o, 0, "R8 tx flush");
    chk(tx_irq_o, 1, "R7 empty");
    // mixed traffic
    for (int i = 0; i < 40; i++) begin
      rx_push_i = (i % 3) != 0; rx_data_i = 8'(i * 7);
      rx_pop_i = (i % 4) == 0;
      tx_push_i = (i % 2) == 0; tx_data_i = 8'(i * 5);
      tx_pop_i = (i % 5) == 0;
      tick();
    end
    for (int i = 0; i < 20; i++) begin
      tx_push_i = 1; tx_data_i = 8'(i); tick();
    end
    chk(tx_count_o, 16, "R3 tx full");
    chk(tx_overrun_o, 1, "R3 tx overrun");
    tick();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule